// File: doc/BRIEF.md
# ECC-protected local SRAM buffer

This block is a 512-word by 64-bit local memory (4096 bytes) guarded by a single-error-correct, double-error-detect code. Each write encodes the data word into a 72-bit codeword: 64 data bits, 7 Hamming check bits and one overall parity bit. The codeword is stored in a register-modelled array. A read returns the word one cycle later. When protection is on, the returned word is corrected where possible, and one of two one-cycle notification outputs tells a system manager what was found.

Protection is off after reset and a configuration write has to turn it on. Check bits are written in either state, so words stored while protection was off can still be corrected once it is on. For testing the fault paths, two request inputs corrupt the next write on purpose. One flips a single data bit and the other flips two.

Top module: `ecc_sram_buf`

## Requirements
- R1: Each of the 512 addresses (0 to 511) holds its own 64-bit word. A write to one address leaves every other address unchanged.
- R2: A read issued in cycle k (`en`=1, `we`=0) sets `rdata` after the clock edge that ends cycle k. `rdata` then holds that value until the next read completes, through idle cycles and writes. After reset `rdata` is 0.
- R3: After reset protection is off. While it is off, a read returns the stored data bits unchanged, including any injected flips, and neither `err_corr` nor `err_uncorr` asserts.
- R4: A cycle with `cfg_we`=1 loads `cfg_ecc_en` as the protection state. The new state applies to reads issued in later cycles.
- R5: A single-bit injection request flips stored data bit 0 of the next write. A request raised in the same cycle as a write applies to that write. A later read with protection on returns the original data, and `err_corr` is 1 for exactly the cycle in which that data appears.
- R6: A double-bit injection request flips stored data bits 0 and 1 of the next write. A later read with protection on returns the stored word uncorrected (original data XOR 3), and `err_uncorr` is 1 for exactly the cycle in which that data appears.
- R7: Each injection request is consumed by one write only. The following write stores clean data, and reading it with protection on returns it exactly with no notification.
- R8: When single and double requests are both pending at a write, the double-bit corruption is applied.
- R9: A word written without injection and read with protection on comes back exactly, with both notification outputs at 0.
- R10: `err_corr` and `err_uncorr` are never both 1. Either one is 1 only in the cycle after a read was issued, never after a write or an idle cycle.
- R11: Check bits are stored even while protection is off. A word written with an injected single-bit error while protection was off is corrected, and flagged on `err_corr`, when it is read after protection is turned on.
- R12: A pending injection request persists through idle cycles and reads. It affects neither the read data nor the flags of those reads, and it applies to the next write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load the protection state from `cfg_ecc_en` |
| cfg_ecc_en | input | 1 | Protection state to load: 1 on, 0 off |
| inj_one | input | 1 | Request a single-bit flip (data bit 0) on the next write |
| inj_two | input | 1 | Request a double-bit flip (data bits 0 and 1) on the next write |
| en | input | 1 | Access strobe for this cycle |
| we | input | 1 | With `en`: 1 for a write, 0 for a read |
| addr | input | 9 | Word address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid the cycle after a read |
| err_corr | output | 1 | One-cycle pulse: single-bit error found and corrected |
| err_uncorr | output | 1 | One-cycle pulse: uncorrectable double-bit error found |

## Verification
The assertions check on every cycle the invariants that relate ports to state:
- the two notification outputs are never high together;
- a notification only follows a read;
- a notification needs protection to have been on;
- a configuration write takes effect on the next cycle;
- a write with no fresh request leaves no injection pending.

Only the bench's scenarios can show that the code works. These scenarios cover:
- which bits are flipped;
- that single errors are corrected and double errors are left uncorrected;
- that words written while protection was off carry valid check bits;
- that an injection request is consumed by exactly one write;
- the precedence of double over single;
- that `rdata` holds between reads.

// File: rtl/ecc_buf_pkg.sv
`timescale 1ns/1ps
package ecc_buf_pkg;

   // Smallest number of Hamming check bits r with 2^r >= dw + r + 1.
   function automatic int ham_bits(int dw);
      int r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   // Codeword position of data bit j: positions that are not powers of two, counted upward from 3.
   function automatic int data_pos(int j);
      int res = 0;
      int cnt = 0;
      for (int p = 3; (p < 65536) && (res == 0); p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == j) res = p;
            cnt++;
         end
      end
      return res;
   endfunction

   typedef enum logic [1:0] {
      INJ_NONE = 2'd0,
      INJ_ONE  = 2'd1,
      INJ_TWO  = 2'd2
   } inj_sel_e;

endpackage

// File: rtl/ecc_encode.sv
`timescale 1ns/1ps
module ecc_encode #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = ecc_buf_pkg::ham_bits(DATA_W)
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);

   // Data bits whose codeword position has bit i set.
   function automatic logic [DATA_W-1:0] cover_mask(int i);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int j = 0; j < DATA_W; j++) begin
         if (((ecc_buf_pkg::data_pos(j) >> i) & 1) != 0) m[j] = 1'b1;
      end
      return m;
   endfunction

   for (genvar i = 0; i < CHK_W; i++) begin : g_chk
      localparam logic [DATA_W-1:0] MASK = cover_mask(i);
      assign chk[i] = ^(data & MASK);
   end

endmodule

// File: rtl/ecc_decode.sv
`timescale 1ns/1ps
module ecc_decode #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = ecc_buf_pkg::ham_bits(DATA_W),
   parameter int CW_W   = DATA_W + CHK_W + 1
) (
   input  logic [CW_W-1:0]   cw,
   output logic [DATA_W-1:0] data_raw,
   output logic [DATA_W-1:0] data_fix,
   output logic              sgl,
   output logic              dbl
);

   localparam int               TOP_POS = DATA_W + CHK_W;
   localparam logic [CHK_W-1:0] TOP_V   = CHK_W'(TOP_POS);

   logic [CHK_W-1:0] chk_new;
   logic [CHK_W-1:0] syn;
   logic             par_bad;
   logic             in_range;

   assign data_raw = cw[DATA_W-1:0];

   ecc_encode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_recalc (
      .data (data_raw),
      .chk  (chk_new)
   );

   assign syn      = chk_new ^ cw[DATA_W +: CHK_W];
   assign par_bad  = ^cw;
   assign in_range = (syn <= TOP_V);
   assign sgl      = par_bad & in_range;
   assign dbl      = (~par_bad & (syn != '0)) | (par_bad & ~in_range);

   for (genvar j = 0; j < DATA_W; j++) begin : g_fix
      localparam logic [CHK_W-1:0] POS_V = CHK_W'(ecc_buf_pkg::data_pos(j));
      assign data_fix[j] = data_raw[j] ^ (sgl & (syn == POS_V));
   end

endmodule

// File: rtl/ecc_inject.sv
`timescale 1ns/1ps
module ecc_inject #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_one,
   input  logic              req_two,
   input  logic              wr_fire,
   output logic [DATA_W-1:0] flip,
   output logic              pend
);
   import ecc_buf_pkg::*;

   logic     one_q, two_q;
   inj_sel_e sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         one_q <= 1'b0;
         two_q <= 1'b0;
      end else if (wr_fire) begin
         one_q <= 1'b0;
         two_q <= 1'b0;
      end else begin
         if (req_one) one_q <= 1'b1;
         if (req_two) two_q <= 1'b1;
      end
   end

   always_comb begin
      if (two_q | req_two)      sel = INJ_TWO;
      else if (one_q | req_one) sel = INJ_ONE;
      else                      sel = INJ_NONE;
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_flip
      if (b == 0) begin : g_b0
         assign flip[b] = wr_fire & (sel != INJ_NONE);
      end else if (b == 1) begin : g_b1
         assign flip[b] = wr_fire & (sel == INJ_TWO);
      end else begin : g_bx
         assign flip[b] = 1'b0;
      end
   end

   assign pend = one_q | two_q;

endmodule

// File: rtl/ecc_store.sv
`timescale 1ns/1ps
module ecc_store #(
   parameter int WORD_W = 73,
   parameter int DEPTH  = 512,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wword,
   output logic [WORD_W-1:0] rword
);

   logic [WORD_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (en && we) cells[addr] <= wword;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rword <= '0;
      else if (en && !we)  rword <= cells[addr];
   end

endmodule

// File: rtl/ecc_sram_buf.sv
`timescale 1ns/1ps
module ecc_sram_buf #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 512,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_ecc_en,
   input  logic              inj_one,
   input  logic              inj_two,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              err_corr,
   output logic              err_uncorr
);

   localparam int CHK_W = ecc_buf_pkg::ham_bits(DATA_W);
   localparam int CW_W  = DATA_W + CHK_W + 1;

   if (DATA_W < 2) begin : g_bad_width
      initial $fatal(1, "ecc_sram_buf: DATA_W must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      initial $fatal(1, "ecc_sram_buf: DEPTH must be at least 2");
   end
   if ((1 << ADDR_W) < DEPTH) begin : g_bad_addr
      initial $fatal(1, "ecc_sram_buf: ADDR_W too narrow for DEPTH");
   end

   logic              ecc_on_q;
   logic              ecc_rd_q;
   logic              rd_live_q;
   logic              wr_fire, rd_fire;
   logic [DATA_W-1:0] flip_mask;
   logic              inj_pend;
   logic [CHK_W-1:0]  ham;
   logic              par;
   logic [CW_W-1:0]   wword, rword;
   logic [DATA_W-1:0] d_raw, d_fix;
   logic              sgl, dbl;

   assign wr_fire = en & we;
   assign rd_fire = en & ~we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ecc_on_q <= 1'b0;
      else if (cfg_we) ecc_on_q <= cfg_ecc_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_live_q <= 1'b0;
         ecc_rd_q  <= 1'b0;
      end else begin
         rd_live_q <= rd_fire;
         if (rd_fire) ecc_rd_q <= ecc_on_q;
      end
   end

   ecc_inject #(.DATA_W(DATA_W)) u_inj (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_one (inj_one),
      .req_two (inj_two),
      .wr_fire (wr_fire),
      .flip    (flip_mask),
      .pend    (inj_pend)
   );

   ecc_encode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
      .data (wdata),
      .chk  (ham)
   );

   assign par   = ^{ham, wdata};
   assign wword = {par, ham, wdata ^ flip_mask};

   ecc_store #(.WORD_W(CW_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .we    (we),
      .addr  (addr),
      .wword (wword),
      .rword (rword)
   );

   ecc_decode #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_dec (
      .cw       (rword),
      .data_raw (d_raw),
      .data_fix (d_fix),
      .sgl      (sgl),
      .dbl      (dbl)
   );

   assign rdata      = ecc_rd_q ? d_fix : d_raw;
   assign err_corr   = rd_live_q & ecc_rd_q & sgl;
   assign err_uncorr = rd_live_q & ecc_rd_q & dbl;

endmodule

// File: rtl/ecc_sram_buf_chk.sv
`timescale 1ns/1ps
module ecc_sram_buf_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_we,
   input logic cfg_ecc_en,
   input logic inj_one,
   input logic inj_two,
   input logic en,
   input logic we,
   input logic err_corr,
   input logic err_uncorr,
   input logic ecc_on,
   input logic inj_pend
);

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_corr && err_uncorr)); // R10

   AST_FLAG_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (err_corr || err_uncorr) |-> $past(en && !we)); // R10

   AST_FLAG_NEEDS_ECC: assert property (@(posedge clk) disable iff (!rst_n)
      (err_corr || err_uncorr) |-> $past(ecc_on)); // R3

   AST_CFG_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (ecc_on == $past(cfg_ecc_en))); // R4

   AST_INJ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && we && !inj_one && !inj_two) |=> !inj_pend); // R7

endmodule

bind ecc_sram_buf ecc_sram_buf_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_ecc_en (cfg_ecc_en),
   .inj_one    (inj_one),
   .inj_two    (inj_two),
   .en         (en),
   .we         (we),
   .err_corr   (err_corr),
   .err_uncorr (err_uncorr),
   .ecc_on     (ecc_on_q),
   .inj_pend   (inj_pend)
);

// File: tb/ecc_sram_buf_test.sv
`timescale 1ns/1ps
module ecc_sram_buf_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_ecc_en = 1'b0;
   logic        inj_one = 1'b0, inj_two = 1'b0;
   logic        en = 1'b0, we = 1'b0;
   logic [8:0]  addr = '0;
   logic [63:0] wdata = '0;
   logic [63:0] rdata;
   logic        err_corr, err_uncorr;

   int total = 0;
   int fails = 0;

   logic [63:0] r_data;
   logic        r_corr, r_unc;

   always #4 clk = ~clk;

   ecc_sram_buf uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ecc_en(cfg_ecc_en),
      .inj_one(inj_one), .inj_two(inj_two), .en(en), .we(we), .addr(addr),
      .wdata(wdata), .rdata(rdata), .err_corr(err_corr), .err_uncorr(err_uncorr)
   );

   typedef struct packed {
      logic [8:0]  a;
      logic [63:0] d;
      logic [1:0]  inj;   // 0 none, 1 single, 2 double
      logic        ecc;
      logic [63:0] exp;
      logic        corr;
      logic        unc;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{9'd0,   64'h0123_4567_89AB_CDEF, 2'd0, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0},
      '{9'd511, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0},
      '{9'd5,   64'hA5A5_A5A5_A5A5_A5A5, 2'd2, 1'b1, 64'hA5A5_A5A5_A5A5_A5A6, 1'b0, 1'b1},
      '{9'd100, 64'h0000_0000_0000_0000, 2'd1, 1'b0, 64'h0000_0000_0000_0001, 1'b0, 1'b0},
      '{9'd200, 64'h5555_5555_5555_5555, 2'd2, 1'b0, 64'h5555_5555_5555_5556, 1'b0, 1'b0},
      '{9'd300, 64'h8000_0000_0000_0000, 2'd1, 1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b0},
      '{9'd1,   64'hDEAD_BEEF_CAFE_F00D, 2'd0, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, 1'b0},
      '{9'd2,   64'h0000_0000_0000_0003, 2'd2, 1'b1, 64'h0000_0000_0000_0000, 1'b0, 1'b1}
   };

   task automatic chk_w(string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_b(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic set_ecc(logic v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ecc_en = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic request(logic one, logic two);
      @(negedge clk);
      inj_one = one; inj_two = two;
      @(negedge clk);
      inj_one = 1'b0; inj_two = 1'b0;
   endtask

   task automatic write(logic [8:0] a, logic [63:0] d, logic one, logic two);
      @(negedge clk);
      en = 1'b1; we = 1'b1; addr = a; wdata = d; inj_one = one; inj_two = two;
      @(negedge clk);
      en = 1'b0; we = 1'b0; inj_one = 1'b0; inj_two = 1'b0;
   endtask

   // Issues a read; samples outputs at the negedge after the capturing edge.
   task automatic read(logic [8:0] a);
      @(negedge clk);
      en = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      en = 1'b0;
      r_data = rdata; r_corr = err_corr; r_unc = err_uncorr;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      chk_w("R2 rdata after reset", rdata, 64'h0);
      chk_b("R10 err_corr after reset", err_corr, 1'b0);
      chk_b("R10 err_uncorr after reset", err_uncorr, 1'b0);

      // R3: protection off after reset, raw data returned
      request(1'b1, 1'b0);
      write(9'd50, 64'h1111_2222_3333_4444, 1'b0, 1'b0);
      read(9'd50);
      chk_w("R3 raw data with ECC off", r_data, 64'h1111_2222_3333_4445);
      chk_b("R3 no corr flag with ECC off", r_corr, 1'b0);
      chk_b("R3 no uncorr flag with ECC off", r_unc, 1'b0);

      // Vector table: R5 R6 R9 R3
      for (int i = 0; i < NV; i++) begin
         set_ecc(VECS[i].ecc);
         if (VECS[i].inj == 2'd1) request(1'b1, 1'b0);
         if (VECS[i].inj == 2'd2) request(1'b0, 1'b1);
         write(VECS[i].a, VECS[i].d, 1'b0, 1'b0);
         read(VECS[i].a);
         chk_w($sformatf("R5/R6/R9 vec%0d data", i), r_data, VECS[i].exp);
         chk_b($sformatf("R5 vec%0d err_corr", i), r_corr, VECS[i].corr);
         chk_b($sformatf("R6 vec%0d err_uncorr", i), r_unc, VECS[i].unc);
         @(negedge clk);
         chk_b($sformatf("R5 vec%0d corr pulse ends", i), err_corr, 1'b0);
         chk_b($sformatf("R6 vec%0d uncorr pulse ends", i), err_uncorr, 1'b0);
      end

      // R1: addresses are independent (ECC on now)
      read(9'd0);
      chk_w("R1 addr 0 kept", r_data, 64'h0123_4567_89AB_CDEF);
      read(9'd1);
      chk_w("R1 addr 1 kept", r_data, 64'hDEAD_BEEF_CAFE_F00D);
      read(9'd511);
      chk_w("R1 addr 511 kept", r_data, 64'hFFFF_FFFF_FFFF_FFFF);
      chk_b("R1 addr 511 still corrected", r_corr, 1'b1);

      // R11: written with ECC off and single injection, now corrected
      read(9'd100);
      chk_w("R11 corrected data", r_data, 64'h0);
      chk_b("R11 err_corr", r_corr, 1'b1);

      // R4: turning protection off and on
      set_ecc(1'b0);
      read(9'd5);
      chk_w("R4 off: raw data", r_data, 64'hA5A5_A5A5_A5A5_A5A6);
      chk_b("R4 off: no uncorr", r_unc, 1'b0);
      set_ecc(1'b1);
      read(9'd5);
      chk_b("R4 on: uncorr", r_unc, 1'b1);

      // R2: rdata holds through idle cycles and a write
      read(9'd1);
      repeat (3) @(negedge clk);
      chk_w("R2 hold idle", rdata, 64'hDEAD_BEEF_CAFE_F00D);
      write(9'd20, 64'h7777_0000_7777_0000, 1'b0, 1'b0);
      chk_w("R2 hold across write", rdata, 64'hDEAD_BEEF_CAFE_F00D);
      chk_b("R10 no corr after write", err_corr, 1'b0);
      chk_b("R10 no uncorr after write", err_uncorr, 1'b0);

      // R7: one request, one write
      request(1'b1, 1'b0);
      write(9'd21, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0, 1'b0);
      write(9'd22, 64'hF0F0_F0F0_F0F0_F0F0, 1'b0, 1'b0);
      read(9'd22);
      chk_w("R7 following write clean data", r_data, 64'hF0F0_F0F0_F0F0_F0F0);
      chk_b("R7 following write no corr", r_corr, 1'b0);
      chk_b("R7 following write no uncorr", r_unc, 1'b0);

      // R8: both requested, double wins
      request(1'b1, 1'b1);
      write(9'd30, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0);
      read(9'd30);
      chk_w("R8 double applied data", r_data, 64'h1234_5678_9ABC_DEF3);
      chk_b("R8 uncorr", r_unc, 1'b1);
      chk_b("R8 no corr", r_corr, 1'b0);

      // R5: request in the same cycle as the write
      write(9'd40, 64'h0000_FFFF_0000_FFFF, 1'b1, 1'b0);
      read(9'd40);
      chk_w("R5 same-cycle data", r_data, 64'h0000_FFFF_0000_FFFF);
      chk_b("R5 same-cycle corr", r_corr, 1'b1);

      // R12: request persists through idle and a read
      request(1'b0, 1'b1);
      repeat (3) @(negedge clk);
      read(9'd0);
      chk_w("R12 intervening read data", r_data, 64'h0123_4567_89AB_CDEF);
      chk_b("R12 intervening read no corr", r_corr, 1'b0);
      chk_b("R12 intervening read no uncorr", r_unc, 1'b0);
      write(9'd31, 64'hCAFE_CAFE_CAFE_CAF0, 1'b0, 1'b0);
      read(9'd31);
      chk_w("R12 applied data", r_data, 64'hCAFE_CAFE_CAFE_CAF3);
      chk_b("R12 applied uncorr", r_unc, 1'b1);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule